// File: doc/BRIEF.md
# Serial Link Data Valid Detector

This block judges whether a recovered 8b/10b line stream carries sound data. The stream arrives one bit at a time, each bit marked by a bit-valid strobe. The block watches for two faults. The first is a run of identical bits that is too long. The second is an observation window that passes without any positive-disparity comma pattern. The result of each window drives a single data-ok flag.

Time is cut into fixed windows of 2^LOG2_WIN accepted bits. The window length defaults to 2^15 and can be shortened for simulation. At the end of each window the block reaches a good or bad verdict.

A frame-select input picks how the verdicts move the flag:
- In per-window mode the flag follows every verdict.
- In hysteresis mode the flag only changes after a streak of HYST equal verdicts (four by default), in either direction.

Top module: `link_valid_qualifier`

## Requirements
- R1: A synchronous active-high `rst` drives `data_ok` low, clears both streak counters and makes per-window mode the mode in force.
- R2: A bit on `bit_in` is taken only in a cycle where `bit_valid` is high. Cycles with `bit_valid` low advance neither the window position nor the run and comma histories.
- R3: Six or more identical accepted bits in a row make the window bad; a run of five is allowed. The window charged is the one in which the sixth bit arrives.
- R4: A comma is the sequence 0,0,1,1,1,1,1 in arrival order, the first-arriving bit written leftmost. A window in which no comma completes is bad.
- R5: Run and comma histories carry over window boundaries, so a run or comma that straddles a boundary counts in the window where its last bit lands. The per-window error and comma-seen marks restart at every boundary.
- R6: In per-window mode (`frame_sel` low), `data_ok` takes the verdict of the window just closed: high for good, low for bad. The new value is visible in the cycle after the window's last bit is accepted.
- R7: In hysteresis mode (`frame_sel` high), `data_ok` falls only after four consecutive bad windows and rises only after four consecutive good windows. One window of the opposite verdict restarts the streak.
- R8: `data_ok` changes only at the clock edge that accepts the last bit of a window and is held constant between boundaries.
- R9: `frame_sel` is sampled only at window boundaries. At a boundary where it differs from the mode in force:
  - the new mode is adopted;
  - both streak counters are cleared;
  - `data_ok` is held, and the closing window's verdict is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Recovered serial bit |
| bit_valid | input | 1 | Strobe marking `bit_in` as a new bit this cycle |
| frame_sel | input | 1 | 0 = per-window decision, 1 = four-window hysteresis |
| data_ok | output | 1 | High when the stream is judged valid |

## Verification
Two events can fall in the same cycle: closing a window, and a fault or comma completing on that same bit, whether the window's last bit or a bit just past the boundary.

The bench provokes both sides of this case:
- One window's sixth identical bit is its final bit.
- A comma begins in one window and ends two bits into the next.
- A run of ones spans a boundary and reaches six inside the following window.

In each case the flag after the boundary must show the verdict charged to the correct window. A mode change landing on a boundary is judged the same way: the flag is held and the hysteresis streak restarts.

// File: rtl/link_valid_qualifier.sv
module link_valid_qualifier #(
  parameter int LOG2_WIN = 15,
  parameter int MAX_RUN  = 5,
  parameter int HYST     = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  input  logic bit_valid,
  input  logic frame_sel,
  output logic data_ok
);
  localparam int RW = $clog2(MAX_RUN + 2);
  localparam int HW = $clog2(HYST + 1);
  localparam logic [6:0] COMMA = 7'b0011111;

  logic [LOG2_WIN-1:0] pos;
  logic [5:0]          hist;
  logic                last_bit;
  logic [RW-1:0]       run_len;
  logic                int_err, int_comma, mode_q;
  logic [HW-1:0]       good_run, bad_run;

  wire           at_end      = bit_valid && (&pos);
  wire           same        = (run_len != '0) && (bit_in == last_bit);
  wire [RW-1:0]  run_nxt     = !same ? RW'(1) :
                               (run_len == RW'(MAX_RUN + 1)) ? run_len : run_len + 1'b1;
  wire           rlv_now     = bit_valid && (run_nxt > RW'(MAX_RUN));
  wire           comma_now   = bit_valid && ({hist, bit_in} == COMMA);
  wire           iv_bad      = int_err || rlv_now || !(int_comma || comma_now);
  wire           switch_mode = (frame_sel != mode_q);
  wire [HW-1:0]  good_inc    = (good_run == HW'(HYST)) ? good_run : good_run + 1'b1;
  wire [HW-1:0]  bad_inc     = (bad_run  == HW'(HYST)) ? bad_run  : bad_run  + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos      <= '0;
      hist     <= '1;
      last_bit <= 1'b0;
      run_len  <= '0;
    end else if (bit_valid) begin
      pos      <= pos + 1'b1;
      hist     <= {hist[4:0], bit_in};
      last_bit <= bit_in;
      run_len  <= run_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_err   <= 1'b0;
      int_comma <= 1'b0;
    end else if (at_end) begin
      int_err   <= 1'b0;
      int_comma <= 1'b0;
    end else begin
      int_err   <= int_err   || rlv_now;
      int_comma <= int_comma || comma_now;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= 1'b0;
      good_run <= '0;
      bad_run  <= '0;
      data_ok  <= 1'b0;
    end else if (at_end) begin
      if (switch_mode) begin
        mode_q   <= frame_sel;
        good_run <= '0;
        bad_run  <= '0;
      end else if (iv_bad) begin
        bad_run  <= bad_inc;
        good_run <= '0;
        if (!mode_q || bad_inc == HW'(HYST)) data_ok <= 1'b0;
      end else begin
        good_run <= good_inc;
        bad_run  <= '0;
        if (!mode_q || good_inc == HW'(HYST)) data_ok <= 1'b1;
      end
    end
  end

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!data_ok && good_run == '0 && bad_run == '0 && !mode_q));

  assert_gate_R2: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |=> ($stable(pos) && $stable(run_len) && $stable(hist)));

  assert_run_R3: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && !at_end && same && run_len >= RW'(MAX_RUN)) |=> int_err);

  assert_comma_R4: assert property (@(posedge clk) disable iff (rst)
    (comma_now && !at_end) |=> int_comma);

  assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
    at_end |=> (!int_err && !int_comma));

  assert_single_R6: assert property (@(posedge clk) disable iff (rst)
    (at_end && !switch_mode && !mode_q && int_err) |=> !data_ok);

  assert_multi_R7: assert property (@(posedge clk) disable iff (rst)
    (at_end && !switch_mode && mode_q && data_ok && bad_run < HW'(HYST - 1)) |=> data_ok);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !at_end |=> $stable(data_ok));

  assert_switch_R9: assert property (@(posedge clk) disable iff (rst)
    (at_end && switch_mode) |=> ($stable(data_ok) && good_run == '0 && bad_run == '0));
endmodule

// File: tb/test_link_valid_qualifier.sv
module test_link_valid_qualifier;
  localparam int LOG2_WIN = 6;
  localparam int WIN = 1 << LOG2_WIN;
  localparam logic [9:0] KPAT = 10'b0101111100;
  localparam int GOOD = 0, NOCOM = 1, RLV = 2, SPA = 3, SPB = 4, SPC = 5;
  localparam int NSTEP = 28;
  // {frame_sel, kind[2:0], expected data_ok}
  localparam logic [4:0] STEPS [NSTEP] = '{
    {1'b0,3'd0,1'b1}, {1'b0,3'd1,1'b0}, {1'b0,3'd0,1'b1}, {1'b0,3'd2,1'b0},
    {1'b0,3'd0,1'b1}, {1'b0,3'd3,1'b1}, {1'b0,3'd4,1'b1}, {1'b0,3'd3,1'b1},
    {1'b0,3'd5,1'b0}, {1'b0,3'd0,1'b1}, {1'b1,3'd0,1'b1}, {1'b1,3'd1,1'b1},
    {1'b1,3'd1,1'b1}, {1'b1,3'd0,1'b1}, {1'b1,3'd1,1'b1}, {1'b1,3'd2,1'b1},
    {1'b1,3'd1,1'b1}, {1'b1,3'd2,1'b0}, {1'b1,3'd0,1'b0}, {1'b1,3'd0,1'b0},
    {1'b1,3'd0,1'b0}, {1'b1,3'd1,1'b0}, {1'b1,3'd0,1'b0}, {1'b1,3'd0,1'b0},
    {1'b1,3'd0,1'b0}, {1'b1,3'd0,1'b1}, {1'b0,3'd1,1'b1}, {1'b0,3'd1,1'b0}
  };
  localparam string TAGS [NSTEP] = '{
    "R6","R4","R6","R3","R6","R6","R5","R6","R5","R6","R9","R7",
    "R7","R7","R7","R7","R7","R7","R7","R7","R7","R7","R7","R7",
    "R7","R7","R9","R6"
  };

  logic clk = 1'b0, rst = 1'b1, bit_in = 1'b0, bit_valid = 1'b0, frame_sel = 1'b0;
  logic data_ok;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  link_valid_qualifier #(.LOG2_WIN(LOG2_WIN)) i_link_valid_qualifier (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_valid(bit_valid),
    .frame_sel(frame_sel), .data_ok(data_ok));

  function automatic logic [WIN-1:0] make_iv(input int kind);
    logic [WIN-1:0] v;
    for (int k = 0; k < WIN; k++) begin
      case (kind)
        NOCOM:   v[k] = k[0];
        RLV:     v[k] = (k >= WIN - 6) ? 1'b1 : KPAT[k % 10];
        SPA:     v[k] = (k >= WIN - 5) ? (k >= WIN - 3) : KPAT[k % 10];
        SPB:     v[k] = (k < 2) ? 1'b1 : k[0];
        SPC:     v[k] = (k < 3) ? 1'b1 : KPAT[(k - 3) % 10];
        default: v[k] = KPAT[k % 10];
      endcase
    end
    return v;
  endfunction

  task automatic send_range(input logic [WIN-1:0] v, input int lo, input int hi, input bit gap);
    for (int k = lo; k <= hi; k++) begin
      @(negedge clk); bit_in = v[k]; bit_valid = 1'b1;
      if (gap) begin
        @(negedge clk); bit_valid = 1'b0; bit_in = 1'b1;
      end
    end
    @(negedge clk); bit_valid = 1'b0;
  endtask

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: data_ok=%0b expected %0b", req, got, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(data_ok, 1'b0, "R1 in reset");
    rst = 1'b0;

    for (int i = 0; i < NSTEP; i++) begin
      frame_sel = STEPS[i][4];
      send_range(make_iv(int'(STEPS[i][3:1])), 0, WIN - 1, 1'b0);
      check(data_ok, STEPS[i][0], TAGS[i]);
    end

    // R2: idle cycles carry bit_in=1 between accepted bits
    send_range(make_iv(GOOD), 0, WIN - 1, 1'b1);
    check(data_ok, 1'b1, "R2 gated bits");

    // R8: flag held until the last bit of a bad window, then R6 drop
    send_range(make_iv(NOCOM), 0, WIN - 2, 1'b0);
    repeat (5) @(negedge clk);
    check(data_ok, 1'b1, "R8 hold mid-window");
    send_range(make_iv(NOCOM), WIN - 1, WIN - 1, 1'b0);
    check(data_ok, 1'b0, "R6 drop at boundary");

    // R1: reset mid-window, then mode must restart as per-window
    send_range(make_iv(GOOD), 0, WIN - 1, 1'b0);
    send_range(make_iv(GOOD), 0, 20, 1'b0);
    rst = 1'b1; frame_sel = 1'b1;
    repeat (2) @(negedge clk);
    check(data_ok, 1'b0, "R1 after reset");
    rst = 1'b0;
    send_range(make_iv(GOOD), 0, WIN - 1, 1'b0);
    check(data_ok, 1'b0, "R9 switch after reset held");
    for (int j = 0; j < 3; j++) begin
      send_range(make_iv(GOOD), 0, WIN - 1, 1'b0);
      check(data_ok, 1'b0, "R7 streak below four");
    end
    send_range(make_iv(GOOD), 0, WIN - 1, 1'b0);
    check(data_ok, 1'b1, "R7 fourth good rises");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule